// File: doc/BRIEF.md
# Audio Error Recovery Mute Sequencer

This block is the control state machine that protects a six-channel digital amplifier whenever its input stream becomes untrustworthy. A clock fault, a change of sample rate or a change of serial data format makes it force every differential PWM pair into a hard mute, stop the processing pipeline, hold off the control bus and reset the data path. Once the fault is gone it runs a fixed re-initialisation interval. It then passes the modulator outputs through again while a shared volume scale climbs linearly from silence to the programmed level.

Two recovery styles are available. In the normal style the ramp leads straight back to normal running. When the active-low recovery-hold input is low at the moment of the fault, every channel that is not exempt stays at full attenuation after the ramp, so its modulator idles at 50% duty. A channel leaves this latched condition only after its mute request has been raised and then dropped again. A channel can be exempted when the exemption mask is armed. The modulator and the volume multiplier sit outside the block, which drives only their control inputs.

States: RUN (normal), HARD_MUTE (fault present), REINIT (fixed re-initialisation count), RAMP (volume climb), LATCHED (ramp finished, some channel still latched). Transitions: any state to HARD_MUTE on a fault; HARD_MUTE to REINIT once no fault source is active; REINIT to RAMP after the count; RAMP to LATCHED when the ramp ends with a latched channel, otherwise RAMP to RUN; LATCHED to RUN when the last latch is released.

Top module: `recov_mute_seq`

## Requirements
- R1: In HARD_MUTE and REINIT, every bit of `pwm_p` is 0, every bit of `pwm_m` is 1, every bit of `ch_valid` is 0, `vol_scale` is 0 and every bit of `ch_zero` is 1.
- R2: A high level on `clk_err`, `rate_chg` or `fmt_chg` at a clock edge puts the block in HARD_MUTE from that edge on, with `proc_hold`, `dp_reset` and `bus_block` all 1.
- R3: HARD_MUTE holds for as long as any fault input stays high. At the first edge with all fault inputs low, REINIT begins and lasts exactly REINIT_CYCLES (default 1024) cycles, with `dp_reset` 0 and `proc_hold` and `bus_block` 1.
- R4: In RAMP, `pwm_p`/`pwm_m` follow `mod_p`/`mod_m`, `ch_valid` is all 1, and `proc_hold`, `dp_reset` and `bus_block` are 0. `vol_scale` equals floor(`target_vol` × k / 256), where k starts at 0 and rises by one every RAMP_CYCLES/256 cycles (10 by default) until it reaches 256.
- R5: In RUN, the PWM pairs follow the modulator, `ch_valid` is all 1, `vol_scale` equals `target_vol`, and `ch_zero[i]` is the channel's mute request: `mute_n` low, `glob_mute` high or `ch_mute[i]` high.
- R6: A fault during REINIT, RAMP or LATCHED returns the block to HARD_MUTE at the next edge. A later recovery runs the full REINIT count again.
- R7: If `recov_hold_n` is 0 at the edge where a fault is seen, then after the ramp every non-exempt channel has `ch_zero` 1 while `vol_scale` stays at `target_vol` and `ch_valid` is 1.
- R8: A latched channel is released one edge after its mute request falls, provided the request was high at some earlier edge while the channel was latched. The request may come from `mute_n`, `glob_mute` or that channel's `ch_mute` bit. When no channel is still latched, the block returns to RUN.
- R9: A channel whose `bypass_mask` bit is 1 while `bypass_arm` is 1 is never latched. With `bypass_arm` at 0 the mask has no effect.
- R10: A channel whose mute request is held high across a fault keeps `ch_zero` at 1 through RAMP and into RUN.
- R11: While `rst_n` is low, and after it is released, the block behaves as in HARD_MUTE with no fault and no latch pending. It then recovers through REINIT and RAMP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_err | input | 1 | Clock fault level, high while the fault lasts |
| rate_chg | input | 1 | Sample-rate change indication |
| fmt_chg | input | 1 | Serial format change indication |
| recov_hold_n | input | 1 | Low selects latched recovery for the fault being seen |
| mute_n | input | 1 | Global mute pin, active low |
| glob_mute | input | 1 | Global mute register bit |
| ch_mute | input | NUM_CH | Per-channel mute register bits |
| bypass_arm | input | 1 | Arms the latch exemption mask |
| bypass_mask | input | NUM_CH | Channels exempt from latching |
| target_vol | input | VOL_W | Programmed volume scale |
| mod_p | input | NUM_CH | Modulator positive outputs |
| mod_m | input | NUM_CH | Modulator negative outputs |
| pwm_p | output | NUM_CH | Positive PWM outputs to the power stages |
| pwm_m | output | NUM_CH | Negative PWM outputs to the power stages |
| ch_valid | output | NUM_CH | Per-channel output valid |
| ch_zero | output | NUM_CH | Per-channel full attenuation (modulator idles at 50% duty) |
| vol_scale | output | VOL_W | Shared volume scale to the multiplier |
| proc_hold | output | 1 | Suspends signal processing |
| dp_reset | output | 1 | Resets the data path |
| bus_block | output | 1 | Holds off control bus transactions |

## Verification
A wrong state shows at the ports within one clock edge. Hard-mute levels and a low valid mark HARD_MUTE or REINIT, and `dp_reset` separates the two. Pass-through with a partial `vol_scale` marks RAMP, and a latched channel's `ch_zero` marks LATCHED. The REINIT and ramp lengths are therefore checked on the exact edges where `ch_valid` rises and `vol_scale` reaches its midpoint and its target. A latch that is loaded or released wrongly shows in `ch_zero` one edge after the mute request changes.

// File: rtl/recov_pkg.sv
package recov_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_HARD_MUTE = 3'd1,
        ST_REINIT    = 3'd2,
        ST_RAMP      = 3'd3,
        ST_LATCHED   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/recov_fsm.sv
module recov_fsm
    import recov_pkg::*;
#(
    parameter int REINIT_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_evt,
    input  logic       ramp_done,
    input  logic       latch_any,
    input  logic       recov_hold_n,
    output seq_state_t state,
    output logic       hold_cap,
    output logic       latch_load
);

    localparam int CNT_W = $clog2(REINIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REINIT_CYCLES - 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             reinit_end;

    assign reinit_end = (state == ST_REINIT) && (cnt == CNT_LAST);
    assign latch_load = reinit_end && !err_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HARD_MUTE;
        end else begin
            state <= nxt;
        end
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (err_evt) nxt = ST_HARD_MUTE;
            end
            ST_HARD_MUTE: begin
                if (!err_evt) nxt = ST_REINIT;
            end
            ST_REINIT: begin
                if (err_evt)         nxt = ST_HARD_MUTE;
                else if (reinit_end) nxt = ST_RAMP;
            end
            ST_RAMP: begin
                if (err_evt)        nxt = ST_HARD_MUTE;
                else if (ramp_done) nxt = latch_any ? ST_LATCHED : ST_RUN;
            end
            ST_LATCHED: begin
                if (err_evt)         nxt = ST_HARD_MUTE;
                else if (!latch_any) nxt = ST_RUN;
            end
            default: nxt = ST_HARD_MUTE;
        endcase
    end

    // re-initialisation counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state != ST_REINIT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // recovery style captured at every edge that sees a fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cap <= 1'b0;
        end else if (err_evt) begin
            hold_cap <= ~recov_hold_n;
        end
    end

    // R3: REINIT is only entered from HARD_MUTE once faults are gone
    a_r3_reinit_from_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REINIT && $past(state) != ST_REINIT)
            |-> ($past(state) == ST_HARD_MUTE && !$past(err_evt)));

    // R6: a fault during recovery aborts it at the next edge
    a_r6_fault_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && (state == ST_REINIT || state == ST_RAMP || state == ST_LATCHED))
            |=> (state == ST_HARD_MUTE));

endmodule

// File: rtl/recov_ramp.sv
module recov_ramp #(
    parameter int VOL_W       = 8,
    parameter int STEPS       = 256,
    parameter int RAMP_CYCLES = 2560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [VOL_W-1:0] target,
    output logic [VOL_W-1:0] scale,
    output logic             done
);

    localparam int STEP_CYC = (RAMP_CYCLES / STEPS > 0) ? (RAMP_CYCLES / STEPS) : 1;
    localparam int K_W      = $clog2(STEPS + 1);
    localparam int D_W      = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam int P_W      = VOL_W + K_W;

    logic [K_W-1:0] k;
    logic [D_W-1:0] div;
    logic           tick;
    logic [P_W-1:0] prod;
    logic [P_W-1:0] quot;

    assign tick = (div == D_W'(STEP_CYC - 1));
    assign done = (k == K_W'(STEPS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k   <= '0;
            div <= '0;
        end else if (!run) begin
            k   <= '0;
            div <= '0;
        end else if (!done) begin
            if (tick) begin
                div <= '0;
                k   <= k + 1'b1;
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    assign prod  = P_W'(target) * P_W'(k);
    assign quot  = prod / P_W'(STEPS);
    assign scale = quot[VOL_W-1:0];

    // R4: the ramp never passes the programmed level
    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (scale <= target));

    // R4: with a steady target the scale only climbs
    a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(target)) |-> (scale >= $past(scale)));

endmodule

// File: rtl/recov_latch.sv
module recov_latch #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              hold_cap,
    input  logic [NUM_CH-1:0] bypass_eff,
    input  logic [NUM_CH-1:0] mute_req,
    output logic [NUM_CH-1:0] latched,
    output logic              latch_any
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic lat_q;
        logic seen_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_q  <= 1'b0;
                seen_q <= 1'b0;
            end else if (clear) begin
                lat_q  <= 1'b0;
                seen_q <= 1'b0;
            end else if (load) begin
                lat_q  <= hold_cap & ~bypass_eff[i];
                seen_q <= 1'b0;
            end else if (lat_q) begin
                if (mute_req[i]) begin
                    seen_q <= 1'b1;
                end else if (seen_q) begin
                    lat_q  <= 1'b0;
                    seen_q <= 1'b0;
                end
            end
        end

        assign latched[i] = lat_q;

        // R8: a latch is dropped only after a raise-then-release of the mute request
        a_r8_release_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(lat_q) && !$past(clear) && !$past(load))
                |-> ($past(seen_q) && !$past(mute_req[i])));
    end

    assign latch_any = |latched;

endmodule

// File: rtl/recov_outmux.sv
module recov_outmux
    import recov_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int VOL_W  = 8
) (
    input  seq_state_t        state,
    input  logic [NUM_CH-1:0] mod_p,
    input  logic [NUM_CH-1:0] mod_m,
    input  logic [VOL_W-1:0]  ramp_scale,
    input  logic [VOL_W-1:0]  target,
    input  logic [NUM_CH-1:0] mute_req,
    input  logic [NUM_CH-1:0] latched,
    output logic [NUM_CH-1:0] pwm_p,
    output logic [NUM_CH-1:0] pwm_m,
    output logic [NUM_CH-1:0] ch_valid,
    output logic [NUM_CH-1:0] ch_zero,
    output logic [VOL_W-1:0]  vol_scale,
    output logic              proc_hold,
    output logic              dp_reset,
    output logic              bus_block
);

    always_comb begin
        pwm_p     = '0;
        pwm_m     = '1;
        ch_valid  = '0;
        ch_zero   = '1;
        vol_scale = '0;
        proc_hold = 1'b1;
        dp_reset  = 1'b1;
        bus_block = 1'b1;
        unique case (state)
            ST_HARD_MUTE: begin
                dp_reset = 1'b1;
            end
            ST_REINIT: begin
                dp_reset = 1'b0;
            end
            ST_RAMP: begin
                pwm_p     = mod_p;
                pwm_m     = mod_m;
                ch_valid  = '1;
                ch_zero   = latched | mute_req;
                vol_scale = ramp_scale;
                proc_hold = 1'b0;
                dp_reset  = 1'b0;
                bus_block = 1'b0;
            end
            ST_LATCHED: begin
                pwm_p     = mod_p;
                pwm_m     = mod_m;
                ch_valid  = '1;
                ch_zero   = latched | mute_req;
                vol_scale = target;
                proc_hold = 1'b0;
                dp_reset  = 1'b0;
                bus_block = 1'b0;
            end
            ST_RUN: begin
                pwm_p     = mod_p;
                pwm_m     = mod_m;
                ch_valid  = '1;
                ch_zero   = mute_req;
                vol_scale = target;
                proc_hold = 1'b0;
                dp_reset  = 1'b0;
                bus_block = 1'b0;
            end
            default: begin
                dp_reset = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/recov_mute_seq.sv
module recov_mute_seq
    import recov_pkg::*;
#(
    parameter int NUM_CH        = 6,
    parameter int VOL_W         = 8,
    parameter int REINIT_CYCLES = 1024,
    parameter int RAMP_STEPS    = 256,
    parameter int RAMP_CYCLES   = 2560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_err,
    input  logic              rate_chg,
    input  logic              fmt_chg,
    input  logic              recov_hold_n,
    input  logic              mute_n,
    input  logic              glob_mute,
    input  logic [NUM_CH-1:0] ch_mute,
    input  logic              bypass_arm,
    input  logic [NUM_CH-1:0] bypass_mask,
    input  logic [VOL_W-1:0]  target_vol,
    input  logic [NUM_CH-1:0] mod_p,
    input  logic [NUM_CH-1:0] mod_m,
    output logic [NUM_CH-1:0] pwm_p,
    output logic [NUM_CH-1:0] pwm_m,
    output logic [NUM_CH-1:0] ch_valid,
    output logic [NUM_CH-1:0] ch_zero,
    output logic [VOL_W-1:0]  vol_scale,
    output logic              proc_hold,
    output logic              dp_reset,
    output logic              bus_block
);

    seq_state_t        state;
    logic              err_evt;
    logic              hold_cap;
    logic              latch_load;
    logic              ramp_done;
    logic              latch_any;
    logic [VOL_W-1:0]  ramp_scale;
    logic [NUM_CH-1:0] mute_req;
    logic [NUM_CH-1:0] bypass_eff;
    logic [NUM_CH-1:0] latched;

    assign err_evt    = clk_err | rate_chg | fmt_chg;
    assign mute_req   = ch_mute | {NUM_CH{~mute_n | glob_mute}};
    assign bypass_eff = bypass_mask & {NUM_CH{bypass_arm}};

    recov_fsm #(
        .REINIT_CYCLES(REINIT_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_evt     (err_evt),
        .ramp_done   (ramp_done),
        .latch_any   (latch_any),
        .recov_hold_n(recov_hold_n),
        .state       (state),
        .hold_cap    (hold_cap),
        .latch_load  (latch_load)
    );

    recov_ramp #(
        .VOL_W      (VOL_W),
        .STEPS      (RAMP_STEPS),
        .RAMP_CYCLES(RAMP_CYCLES)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RAMP),
        .target(target_vol),
        .scale (ramp_scale),
        .done  (ramp_done)
    );

    recov_latch #(
        .NUM_CH(NUM_CH)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_HARD_MUTE),
        .load      (latch_load),
        .hold_cap  (hold_cap),
        .bypass_eff(bypass_eff),
        .mute_req  (mute_req),
        .latched   (latched),
        .latch_any (latch_any)
    );

    recov_outmux #(
        .NUM_CH(NUM_CH),
        .VOL_W (VOL_W)
    ) u_out (
        .state     (state),
        .mod_p     (mod_p),
        .mod_m     (mod_m),
        .ramp_scale(ramp_scale),
        .target    (target_vol),
        .mute_req  (mute_req),
        .latched   (latched),
        .pwm_p     (pwm_p),
        .pwm_m     (pwm_m),
        .ch_valid  (ch_valid),
        .ch_zero   (ch_zero),
        .vol_scale (vol_scale),
        .proc_hold (proc_hold),
        .dp_reset  (dp_reset),
        .bus_block (bus_block)
    );

    // R1: hard-mute pin levels while muted or re-initialising
    a_r1_hard_mute_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HARD_MUTE || state == ST_REINIT)
            |-> (pwm_p == '0 && pwm_m == '1 && ch_valid == '0 && vol_scale == '0));

    // R2: any fault source leads to hard mute with the bus held off
    a_r2_fault_enters_mute: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> (state == ST_HARD_MUTE && bus_block && proc_hold));

    // R2: the control bus is only blocked as a result of a fault
    a_r2_block_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_block) |-> $past(err_evt));

    // R7: a latched channel is always fully attenuated
    a_r7_latched_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (latched & ~ch_zero) == '0);

    // R9: an exempt channel is never latched at load time
    a_r9_exempt_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
        $past(latch_load) |-> ((latched & $past(bypass_eff)) == '0));

endmodule

// File: tb/recov_mute_seq_test.sv
module recov_mute_seq_test;

    localparam int NCH = 6;
    localparam int VW  = 8;
    // cycles from the first fault-free edge in HARD_MUTE to RUN
    localparam int TO_RUN = 1 + 1023 + 1 + 2560 + 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           clk_err, rate_chg, fmt_chg, recov_hold_n;
    logic           mute_n, glob_mute, bypass_arm;
    logic [NCH-1:0] ch_mute, bypass_mask, mod_p, mod_m;
    logic [VW-1:0]  target_vol;
    logic [NCH-1:0] pwm_p, pwm_m, ch_valid, ch_zero;
    logic [VW-1:0]  vol_scale;
    logic           proc_hold, dp_reset, bus_block;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    recov_mute_seq uut (
        .clk(clk), .rst_n(rst_n), .clk_err(clk_err), .rate_chg(rate_chg),
        .fmt_chg(fmt_chg), .recov_hold_n(recov_hold_n), .mute_n(mute_n),
        .glob_mute(glob_mute), .ch_mute(ch_mute), .bypass_arm(bypass_arm),
        .bypass_mask(bypass_mask), .target_vol(target_vol), .mod_p(mod_p),
        .mod_m(mod_m), .pwm_p(pwm_p), .pwm_m(pwm_m), .ch_valid(ch_valid),
        .ch_zero(ch_zero), .vol_scale(vol_scale), .proc_hold(proc_hold),
        .dp_reset(dp_reset), .bus_block(bus_block)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance n edges, then settle 1 ns past the edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_hard_mute(input string tag);
        chk({tag, " pwm_p"}, 32'(pwm_p), 32'h00);
        chk({tag, " pwm_m"}, 32'(pwm_m), 32'h3F);
        chk({tag, " valid"}, 32'(ch_valid), 32'h00);
        chk({tag, " vol"}, 32'(vol_scale), 32'h00);
        chk({tag, " zero"}, 32'(ch_zero), 32'h3F);
    endtask

    task automatic chk_run(input string tag);
        chk({tag, " pass p"}, 32'(pwm_p), 32'(mod_p));
        chk({tag, " pass m"}, 32'(pwm_m), 32'(mod_m));
        chk({tag, " valid"}, 32'(ch_valid), 32'h3F);
        chk({tag, " vol"}, 32'(vol_scale), 32'(target_vol));
        chk({tag, " bus"}, 32'(bus_block), 32'h0);
    endtask

    task automatic test_reset_powerup();
        rst_n = 1'b0;
        step(3);
        chk_hard_mute("R11 reset");
        chk("R11 reset dp_reset", 32'(dp_reset), 32'h1);
        rst_n = 1'b1;
        step(1);
        chk("R3 reinit dp_reset", 32'(dp_reset), 32'h0);
        chk("R3 reinit proc_hold", 32'(proc_hold), 32'h1);
        chk("R3 reinit bus_block", 32'(bus_block), 32'h1);
        chk_hard_mute("R1 reinit");
        step(1023);
        chk("R3 reinit last cycle valid", 32'(ch_valid), 32'h00);
        step(1);
        chk("R4 ramp start valid", 32'(ch_valid), 32'h3F);
        chk("R4 ramp start vol", 32'(vol_scale), 32'h0);
        chk("R4 ramp pass", 32'(pwm_p), 32'(mod_p));
        chk("R4 ramp proc_hold", 32'(proc_hold), 32'h0);
        step(1280);
        chk("R4 ramp midpoint", 32'(vol_scale), 32'd100);
        step(1280);
        chk("R4 ramp end", 32'(vol_scale), 32'd200);
        step(1);
        chk_run("R5 run");
        chk("R5 run zero", 32'(ch_zero), 32'h00);
    endtask

    task automatic test_clk_err_hold();
        clk_err = 1'b1;
        step(1);
        chk_hard_mute("R2 clk_err");
        chk("R2 clk_err dp_reset", 32'(dp_reset), 32'h1);
        chk("R2 clk_err bus_block", 32'(bus_block), 32'h1);
        chk("R2 clk_err proc_hold", 32'(proc_hold), 32'h1);
        step(5);
        chk("R3 held while fault", 32'(dp_reset), 32'h1);
        clk_err = 1'b0;
        step(TO_RUN);
        chk_run("R3 after hold");
    endtask

    task automatic test_pulse_sources();
        rate_chg = 1'b1;
        step(1);
        chk_hard_mute("R2 rate_chg");
        rate_chg = 1'b0;
        step(TO_RUN);
        chk_run("R2 rate recovery");
        fmt_chg = 1'b1;
        step(1);
        chk_hard_mute("R2 fmt_chg");
        chk("R2 fmt_chg bus", 32'(bus_block), 32'h1);
        fmt_chg = 1'b0;
        step(TO_RUN);
        chk_run("R2 fmt recovery");
    endtask

    task automatic test_err_in_ramp();
        clk_err = 1'b1;
        step(1);
        clk_err = 1'b0;
        step(1 + 1023 + 1 + 500);
        chk("R4 ramp k=50", 32'(vol_scale), 32'd39);
        rate_chg = 1'b1;
        step(1);
        chk_hard_mute("R6 fault in ramp");
        rate_chg = 1'b0;
        step(TO_RUN);
        chk_run("R6 after ramp abort");
    endtask

    task automatic test_err_in_reinit();
        clk_err = 1'b1;
        step(1);
        clk_err = 1'b0;
        step(500);
        fmt_chg = 1'b1;
        step(1);
        chk("R6 fault in reinit dp_reset", 32'(dp_reset), 32'h1);
        fmt_chg = 1'b0;
        step(1 + 1023);
        chk("R6 full reinit again", 32'(ch_valid), 32'h00);
        step(1);
        chk("R6 ramp after full reinit", 32'(ch_valid), 32'h3F);
        step(2561);
        chk_run("R6 recovered");
    endtask

    task automatic test_latched_armed();
        recov_hold_n = 1'b0;
        bypass_arm   = 1'b1;
        bypass_mask  = 6'b000011;
        clk_err      = 1'b1;
        step(1);
        clk_err      = 1'b0;
        recov_hold_n = 1'b1;
        step(TO_RUN);
        chk("R7 latched zero", 32'(ch_zero), 32'h3C);
        chk("R9 exempt channels live", 32'(ch_zero & 6'b000011), 32'h0);
        chk("R7 latched vol", 32'(vol_scale), 32'd200);
        chk("R7 latched valid", 32'(ch_valid), 32'h3F);
        step(100);
        chk("R7 latch persists", 32'(ch_zero), 32'h3C);
        ch_mute[2] = 1'b1;
        step(1);
        chk("R8 ch2 request", 32'(ch_zero), 32'h3C);
        ch_mute[2] = 1'b0;
        step(1);
        chk("R8 ch2 released", 32'(ch_zero), 32'h38);
        mute_n = 1'b0;
        step(1);
        chk("R8 pin mute all", 32'(ch_zero), 32'h3F);
        mute_n = 1'b1;
        step(1);
        chk("R8 pin release", 32'(ch_zero), 32'h00);
        step(1);
        chk_run("R8 back to run");
        bypass_arm  = 1'b0;
        bypass_mask = '0;
    endtask

    task automatic test_latched_unarmed();
        recov_hold_n = 1'b0;
        bypass_arm   = 1'b0;
        bypass_mask  = 6'b111111;
        rate_chg     = 1'b1;
        step(1);
        rate_chg     = 1'b0;
        recov_hold_n = 1'b1;
        step(TO_RUN);
        chk("R9 unarmed mask ignored", 32'(ch_zero), 32'h3F);
        glob_mute = 1'b1;
        step(1);
        glob_mute = 1'b0;
        step(1);
        chk("R8 glob_mute release", 32'(ch_zero), 32'h00);
        step(1);
        chk_run("R8 glob back to run");
        bypass_mask = '0;
    endtask

    task automatic test_silent_transition();
        ch_mute = 6'b000001;
        step(1);
        chk("R5 run mute follow", 32'(ch_zero), 32'h01);
        clk_err = 1'b1;
        step(1);
        clk_err = 1'b0;
        step(1 + 1023 + 1 + 10);
        chk("R10 muted through ramp", 32'(ch_zero), 32'h01);
        step(TO_RUN - (1 + 1023 + 1 + 10));
        chk("R10 muted in run", 32'(ch_zero), 32'h01);
        chk_run("R10 run");
        ch_mute = '0;
        step(1);
        chk("R5 unmute", 32'(ch_zero), 32'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        clk_err      = 1'b0;
        rate_chg     = 1'b0;
        fmt_chg      = 1'b0;
        recov_hold_n = 1'b1;
        mute_n       = 1'b1;
        glob_mute    = 1'b0;
        ch_mute      = '0;
        bypass_arm   = 1'b0;
        bypass_mask  = '0;
        target_vol   = 8'd200;
        mod_p        = 6'b101010;
        mod_m        = 6'b010101;
        #1;
        test_reset_powerup();
        test_clk_err_hold();
        test_pulse_sources();
        test_err_in_ramp();
        test_err_in_reinit();
        test_latched_armed();
        test_latched_unarmed();
        test_silent_transition();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule